// File: doc/BRIEF.md
# Multi-Format PCM Audio Serial Transmitter

This block sends one stereo pair of 24-bit audio samples per frame on a single serial data line. The same port can run as a plain two-channel link, in left-justified or I2S framing, or it can share a time-division multiplexed (TDM) bus with other transmitters. On a TDM bus it occupies one sub-frame of two 32-bit slots. Outside that sub-frame its data output enable is low, so other devices can drive the line.

In master mode the block derives the bit clock and the frame clock from its own clock through a divider. The number of bit clocks per frame depends on both the framing format and the speed mode. In slave mode both clocks come from outside. They are resynchronised into the block's clock, and each frame begins on the detected frame-clock edge. A frame of the wrong length raises an error flag. Samples arrive through a valid/ready handshake into a one-entry holding register, and a new pair is taken at each frame start. If no new pair has arrived, the previous pair is sent again and an underrun flag is raised.

Top module: `pcm_serial_tx`

## Requirements
- R1: Format select 00 is left-justified. The left channel goes out while the frame clock is high and the right channel while it is low. Each channel's MSB is on the first bit of its half-frame. The 24 data bits go MSB first and every remaining bit of the half-frame is 0.
- R2: Format select 01 is I2S. A frame starts on the frame-clock falling edge, and the left channel goes out while the frame clock is low. Each channel's MSB comes one bit clock after the frame-clock edge of its half-frame.
- R3: Format select 10 is TDM and 11 is TDM delayed by one bit. In both, the frame clock is high for the first bit of the frame only. The owned sub-frame holds a left slot and then a right slot, 32 bits each, with 24 data bits MSB first followed by 8 zero bits. In the delayed variant every owned bit moves one bit later, and the last bit of sub-frame 3 wraps into bit 0 of the next frame.
- R4: Speed select 00 is normal, 01 is double, and 10 or 11 is quad. Bits per frame are 128/64/64 for the two-channel formats and 256/128/64 for the TDM formats.
- R5: Sub-frame select values 0 to 3 place the pair at bit 64×n of a TDM frame. In double speed the upper select bit counts as 0. In quad speed both select bits count as 0.
- R6: In the TDM formats the data output enable is high only on the 64 owned bit positions. In the two-channel formats it is high on every bit once framing has started.
- R7: In master mode one bit clock lasts BCK_DIV clock cycles, and the data changes together with the bit clock falling edge.
- R8: In slave mode a frame starts on the first bit clock falling edge at which the resynchronised frame clock shows its start edge (rising, or falling for I2S). Until the first start the output enable stays low.
- R9: In slave mode the framing-error flag is updated at each frame start after the first one. It goes to 1 if the frame just ended did not last exactly the expected number of bits, and otherwise to 0.
- R10: A pair is accepted when in_valid and in_ready are both high. in_ready is low while an accepted pair waits, and the waiting pair becomes the transmitted pair at the next frame start.
- R11: At a frame start with no waiting pair, the previous pair is sent again and the underrun flag goes to 1. At a start with a waiting pair it goes to 0.
- R12: After reset: output enable 0, data 0, both clock outputs 0, in_ready 1, underrun 0 and framing error 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the master clock source |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt | input | 2 | Framing format select |
| cfg_speed | input | 2 | Speed mode select |
| cfg_sub | input | 2 | TDM sub-frame select |
| cfg_master | input | 1 | 1 = generate clocks, 0 = follow external clocks |
| bck_i | input | 1 | External bit clock (slave mode) |
| fck_i | input | 1 | External frame clock (slave mode) |
| bck_o | output | 1 | Generated bit clock (master mode) |
| fck_o | output | 1 | Generated frame clock (master mode) |
| sd_o | output | 1 | Serial data |
| sd_oe_o | output | 1 | Serial data output enable |
| in_valid | input | 1 | Sample pair valid |
| in_ready | output | 1 | Holding register free |
| in_left | input | 24 | Left sample |
| in_right | input | 24 | Right sample |
| underrun_o | output | 1 | Last frame start found no new pair |
| frame_err_o | output | 1 | Last slave frame had the wrong length |

## Verification
The hardest situation to reach from the ports is the framing-error flag. It changes only after the block has locked onto the external frame clock, and only at the edge that ends a frame of the wrong length. The bench acts as the bus master in slave mode. It drives idle bits first, then a run of frames with one frame two bits short, and reads the flag inside each following frame. The wrapped final bit of sub-frame 3 in delayed TDM, and the masking of the sub-frame select bits at higher speeds, are reached by choosing those settings and comparing whole captured frames.

// File: rtl/pcm_serial_pkg.sv
package pcm_serial_pkg;

    localparam int SAMPLE_W   = 24;
    localparam int SLOT_W     = 32;
    localparam int SLOTS_MAX  = 8;
    localparam int FRAME_MAX  = SLOT_W * SLOTS_MAX;
    localparam int IDX_W      = $clog2(FRAME_MAX);
    localparam int SUBFRM_W   = 2 * SLOT_W;

    typedef enum logic [1:0] {
        FMT_LJ      = 2'b00,
        FMT_I2S     = 2'b01,
        FMT_TDM     = 2'b10,
        FMT_TDM_DLY = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        SPD_NORMAL   = 2'b00,
        SPD_DOUBLE   = 2'b01,
        SPD_QUAD     = 2'b10,
        SPD_QUAD_ALT = 2'b11
    } spd_e;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [IDX_W-1:0]    idx_t;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } pair_t;

    typedef struct packed {
        logic en;
        logic d;
    } sd_t;

    function automatic logic is_tdm(fmt_e f);
        return f[1];
    endfunction

    function automatic logic is_delayed(fmt_e f);
        return (f == FMT_I2S) || (f == FMT_TDM_DLY);
    endfunction

    // Bits per frame clock period
    function automatic int frame_bits(fmt_e f, spd_e s);
        int sh;
        sh = (s == SPD_NORMAL) ? 0 : (s == SPD_DOUBLE) ? 1 : 2;
        if (is_tdm(f))
            return FRAME_MAX >> sh;
        return (s == SPD_NORMAL) ? 4 * SLOT_W : 2 * SLOT_W;
    endfunction

    // Sub-frame select after masking for the speed mode
    function automatic int eff_sub(spd_e s, logic [1:0] sub);
        if (s == SPD_NORMAL) return int'(sub);
        if (s == SPD_DOUBLE) return int'(sub[0]);
        return 0;
    endfunction

    // Value and enable of the serial line for one bit position of a frame
    function automatic sd_t bit_out(fmt_e f, spd_e s, logic [1:0] sub,
                                    idx_t idx, pair_t p);
        int  n, i, u, base, r, half, pos;
        logic ch;
        sd_t o;
        n   = frame_bits(f, s);
        i   = int'(idx);
        u   = is_delayed(f) ? ((i == 0) ? n - 1 : i - 1) : i;
        o   = '0;
        ch  = 1'b0;
        pos = SLOT_W;
        if (is_tdm(f)) begin
            base = eff_sub(s, sub) * SUBFRM_W;
            if (u >= base && u < base + SUBFRM_W) begin
                o.en = 1'b1;
                r    = u - base;
                ch   = (r >= SLOT_W);
                pos  = ch ? r - SLOT_W : r;
            end
        end else begin
            half = n / 2;
            o.en = 1'b1;
            ch   = (u >= half);
            pos  = ch ? u - half : u;
        end
        if (o.en && pos < SAMPLE_W)
            o.d = ch ? p.right[SAMPLE_W-1-pos] : p.left[SAMPLE_W-1-pos];
        return o;
    endfunction

endpackage

// File: rtl/pcm_serial_clkgen.sv
module pcm_serial_clkgen #(
    parameter int BCK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic master,
    input  logic bck_i,
    input  logic fck_i,
    output logic tick,
    output logic fck_lvl,
    output logic bck_o
);
    localparam int CW   = (BCK_DIV > 2) ? $clog2(BCK_DIV) : 1;
    localparam int HALF = BCK_DIV / 2;

    logic [CW-1:0] div_q;
    logic [2:0]    bsync_q;
    logic [1:0]    fsync_q;
    logic          wrap;

    assign wrap = (div_q == CW'(BCK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            bck_o   <= 1'b0;
            bsync_q <= '0;
            fsync_q <= '0;
        end else begin
            bsync_q <= {bsync_q[1:0], bck_i};
            fsync_q <= {fsync_q[0], fck_i};
            if (master) begin
                div_q <= wrap ? '0 : div_q + 1'b1;
                if (wrap)
                    bck_o <= 1'b0;
                else if (div_q == CW'(HALF - 1))
                    bck_o <= 1'b1;
            end else begin
                div_q <= '0;
                bck_o <= 1'b0;
            end
        end
    end

    // Tick marks the bit clock falling edge: the cycle in which data advances
    assign tick    = master ? wrap : (bsync_q[2] & ~bsync_q[1]);
    assign fck_lvl = fsync_q[1];

    assert_bck_falls_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
        master && tick |=> !bck_o);
    assert_bck_steady_R7: assert property (@(posedge clk) disable iff (rst)
        master && !tick && (div_q != CW'(HALF - 1)) |=> $stable(bck_o));

endmodule

// File: rtl/pcm_serial_framer.sv
module pcm_serial_framer
    import pcm_serial_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic master,
    input  logic fck_lvl,
    input  fmt_e fmt,
    input  spd_e spd,
    output idx_t idx_nxt,
    output logic start,
    output logic locked,
    output logic ferr,
    output logic fck_o
);
    idx_t idx_q;
    idx_t last;
    idx_t half;
    logic wrapped_q;
    logic prev_q;
    logic prev_ok_q;
    logic start_lvl;
    logic edge_seen;
    logic fck_nxt;

    assign last      = idx_t'(frame_bits(fmt, spd) - 1);
    assign half      = idx_t'(frame_bits(fmt, spd) / 2);
    assign start_lvl = (fmt != FMT_I2S);
    assign edge_seen = prev_ok_q && (prev_q != fck_lvl) && (fck_lvl == start_lvl);
    assign start     = tick && (master ? (!locked || idx_q == last) : edge_seen);
    assign idx_nxt   = (start || idx_q == last) ? '0 : idx_q + 1'b1;

    always_comb begin
        case (fmt)
            FMT_LJ:  fck_nxt = (idx_nxt < half);
            FMT_I2S: fck_nxt = (idx_nxt >= half);
            default: fck_nxt = (idx_nxt == '0);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q     <= '0;
            wrapped_q <= 1'b0;
            prev_q    <= 1'b0;
            prev_ok_q <= 1'b0;
            locked    <= 1'b0;
            ferr      <= 1'b0;
            fck_o     <= 1'b0;
        end else if (tick) begin
            idx_q     <= idx_nxt;
            prev_q    <= fck_lvl;
            prev_ok_q <= 1'b1;
            fck_o     <= master && (locked || start) && fck_nxt;
            if (start) begin
                locked    <= 1'b1;
                ferr      <= locked && ((idx_q != last) || wrapped_q);
                wrapped_q <= 1'b0;
            end else if (idx_q == last) begin
                wrapped_q <= 1'b1;
            end
        end
    end

    assert_idx_in_frame_R4: assert property (@(posedge clk) disable iff (rst)
        locked && master |-> idx_q <= last);
    assert_err_only_at_start_R9: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(ferr));
    assert_start_locks_R8: assert property (@(posedge clk) disable iff (rst)
        start |=> locked);

endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
    import pcm_serial_pkg::*;
#(
    parameter int BCK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  cfg_fmt,
    input  logic [1:0]  cfg_speed,
    input  logic [1:0]  cfg_sub,
    input  logic        cfg_master,
    input  logic        bck_i,
    input  logic        fck_i,
    output logic        bck_o,
    output logic        fck_o,
    output logic        sd_o,
    output logic        sd_oe_o,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [23:0] in_left,
    input  logic [23:0] in_right,
    output logic        underrun_o,
    output logic        frame_err_o
);
    fmt_e  fmt;
    spd_e  spd;
    logic  tick, fck_lvl, start, locked;
    idx_t  idx_nxt;
    pair_t pend_q, cur_q, cur_nxt;
    logic  pend_full;
    logic  take;
    sd_t   nxt_bit;

    assign fmt = fmt_e'(cfg_fmt);
    assign spd = spd_e'(cfg_speed);

    pcm_serial_clkgen #(.BCK_DIV(BCK_DIV)) u_clkgen (
        .clk     (clk),
        .rst     (rst),
        .master  (cfg_master),
        .bck_i   (bck_i),
        .fck_i   (fck_i),
        .tick    (tick),
        .fck_lvl (fck_lvl),
        .bck_o   (bck_o)
    );

    pcm_serial_framer u_framer (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .master  (cfg_master),
        .fck_lvl (fck_lvl),
        .fmt     (fmt),
        .spd     (spd),
        .idx_nxt (idx_nxt),
        .start   (start),
        .locked  (locked),
        .ferr    (frame_err_o),
        .fck_o   (fck_o)
    );

    assign in_ready = !pend_full;
    assign take     = in_valid && in_ready;
    assign cur_nxt  = (start && pend_full) ? pend_q : cur_q;
    assign nxt_bit  = bit_out(fmt, spd, cfg_sub, idx_nxt, cur_nxt);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= '0;
            pend_full  <= 1'b0;
            cur_q      <= '0;
            underrun_o <= 1'b0;
            sd_o       <= 1'b0;
            sd_oe_o    <= 1'b0;
        end else begin
            if (take) begin
                pend_q    <= '{left: in_left, right: in_right};
                pend_full <= 1'b1;
            end else if (start && pend_full) begin
                pend_full <= 1'b0;
            end
            if (start) begin
                cur_q      <= cur_nxt;
                underrun_o <= !pend_full;
            end
            if (tick) begin
                sd_oe_o <= (locked || start) && nxt_bit.en;
                sd_o    <= (locked || start) && nxt_bit.en && nxt_bit.d;
            end
        end
    end

    assert_ready_drops_R10: assert property (@(posedge clk) disable iff (rst)
        take |=> !in_ready);
    assert_waiting_pair_held_R10: assert property (@(posedge clk) disable iff (rst)
        pend_full && !start |=> pend_full && $stable(pend_q));
    assert_quiet_until_lock_R8: assert property (@(posedge clk) disable iff (rst)
        !locked |-> !sd_oe_o);
    assert_underrun_flag_R11: assert property (@(posedge clk) disable iff (rst)
        start && !pend_full |=> underrun_o);

endmodule

// File: tb/test_pcm_serial_tx.sv
module test_pcm_serial_tx;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int SH         = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_fmt = 2'b00, cfg_speed = 2'b00, cfg_sub = 2'b00;
    logic        cfg_master = 1'b0;
    logic        bck_i = 1'b0, fck_i = 1'b0;
    logic        bck_o, fck_o, sd_o, sd_oe_o, in_ready, underrun_o, frame_err_o;
    logic        in_valid = 1'b0;
    logic [23:0] in_left = '0, in_right = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_serial_tx #(.BCK_DIV(DIV)) i_pcm_serial_tx (
        .clk(clk), .rst(rst), .cfg_fmt(cfg_fmt), .cfg_speed(cfg_speed),
        .cfg_sub(cfg_sub), .cfg_master(cfg_master), .bck_i(bck_i), .fck_i(fck_i),
        .bck_o(bck_o), .fck_o(fck_o), .sd_o(sd_o), .sd_oe_o(sd_oe_o),
        .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left),
        .in_right(in_right), .underrun_o(underrun_o), .frame_err_o(frame_err_o)
    );

    int total = 0;
    int bad   = 0;

    logic cap_fck[0:1023], cap_sd[0:1023], cap_oe[0:1023], cap_ur[0:1023];
    logic exp_d[0:255], exp_oe[0:255];
    logic sl_sd[0:4][0:255], sl_oe[0:4][0:255], sl_fe[0:4][0:255];
    int   sl_len[0:4];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int fbits(input logic [1:0] f, input logic [1:0] s);
        int sh;
        sh = (s == 2'd0) ? 0 : (s == 2'd1) ? 1 : 2;
        if (f[1]) return 256 >> sh;
        return (s == 2'd0) ? 128 : 64;
    endfunction

    // Expected line content of one frame, built by placing the slots
    task automatic build_exp(input logic [1:0] f, input logic [1:0] s,
                             input logic [1:0] sub, input logic [23:0] l,
                             input logic [23:0] r);
        int n, d, half, esub, k;
        n = fbits(f, s);
        d = (f == 2'd1 || f == 2'd3) ? 1 : 0;
        for (int i = 0; i < n; i++) begin
            exp_d[i]  = 1'b0;
            exp_oe[i] = !f[1];
        end
        if (!f[1]) begin
            half = n / 2;
            for (int j = 0; j < 24; j++) begin
                exp_d[(j + d) % n]        = l[23-j];
                exp_d[(half + j + d) % n] = r[23-j];
            end
        end else begin
            esub = (s == 2'd0) ? int'(sub) : (s == 2'd1) ? int'(sub[0]) : 0;
            for (int j = 0; j < 64; j++) begin
                k = (esub * 64 + j + d) % n;
                exp_oe[k] = 1'b1;
                if (j < 24)                exp_d[k] = l[23-j];
                else if (j >= 32 && j < 56) exp_d[k] = r[55-j];
                else                        exp_d[k] = 1'b0;
            end
        end
    endtask

    task automatic do_reset(input logic [1:0] f, input logic [1:0] s,
                            input logic [1:0] sub, input logic m);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; bck_i = 1'b0; fck_i = 1'b0;
        cfg_fmt = f; cfg_speed = s; cfg_sub = sub; cfg_master = m;
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push(input logic [23:0] l, input logic [23:0] r);
        @(negedge clk);
        in_valid = 1'b1; in_left = l; in_right = r;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Index 0 holds the state at call time; bits follow at each bit clock rise
    task automatic capture_master(input int nb);
        cap_fck[0] = fck_o; cap_sd[0] = sd_o; cap_oe[0] = sd_oe_o; cap_ur[0] = underrun_o;
        for (int i = 1; i <= nb; i++) begin
            @(posedge bck_o);
            #(CLK_PERIOD/2);
            cap_fck[i] = fck_o; cap_sd[i] = sd_o; cap_oe[i] = sd_oe_o; cap_ur[i] = underrun_o;
        end
    endtask

    function automatic int find_start(input int from, input int len, input logic [1:0] f);
        for (int i = (from < 1 ? 1 : from); i < len; i++) begin
            if (f == 2'd1 ? (cap_fck[i-1] && !cap_fck[i]) : (!cap_fck[i-1] && cap_fck[i]))
                return i;
        end
        return -1;
    endfunction

    task automatic compare_cap(input int k, input int n, input string req, input string what);
        int mism, first;
        mism = 0; first = -1;
        for (int i = 0; i < n; i++) begin
            if (cap_oe[k+i] !== exp_oe[i] || (exp_oe[i] && cap_sd[k+i] !== exp_d[i])) begin
                mism++;
                if (first < 0) first = i;
            end
        end
        check(mism == 0, req, {what, " mismatched bits (first at index in message)"}, mism, 0);
        if (mism != 0) $display("  first differing bit index %0d", first);
    endtask

    task automatic test_reset_state();
        do_reset(2'd0, 2'd0, 2'd0, 1'b0);
        repeat (3) @(negedge clk);
        check(sd_oe_o == 1'b0 && sd_o == 1'b0, "R12", "line after reset", {sd_oe_o, sd_o}, 0);
        check(bck_o == 1'b0 && fck_o == 1'b0, "R12", "clock outputs after reset", {bck_o, fck_o}, 0);
        check(in_ready == 1'b1, "R12", "ready after reset", in_ready, 1);
        check(underrun_o == 1'b0 && frame_err_o == 1'b0, "R12", "flags after reset",
              {underrun_o, frame_err_o}, 0);
    endtask

    task automatic test_master(input logic [1:0] f, input logic [1:0] s, input logic [1:0] sub,
                               input logic [23:0] l, input logic [23:0] r,
                               input string req);
        int n, len, k1, k2;
        n   = fbits(f, s);
        len = 3 * n + 4;
        do_reset(f, s, sub, 1'b1);
        push(l, r);
        capture_master(len);
        k1 = find_start(1, len + 1, f);
        k2 = (k1 > 0) ? find_start(k1 + 1, len + 1, f) : -1;
        check(k1 > 0 && k2 > 0 && (k2 - k1) == n, "R4", "bits per frame", k2 - k1, n);
        if (k2 > 0 && k2 + n <= len + 1) begin
            build_exp(f, s, sub, l, r);
            compare_cap(k2, n, req, "master frame");
        end else begin
            check(1'b0, req, "frame start not found", k2, 0);
        end
    endtask

    task automatic test_bck_period();
        time t0;
        do_reset(2'd0, 2'd0, 2'd0, 1'b1);
        @(posedge bck_o);
        t0 = $time;
        @(posedge bck_o);
        check(($time - t0) == DIV * CLK_PERIOD, "R7", "bit clock period", $time - t0, DIV * CLK_PERIOD);
        @(negedge bck_o);
        #1;
        check(sd_oe_o == 1'b1, "R7", "line driven after first falling edge", sd_oe_o, 1);
    endtask

    task automatic test_handshake_underrun();
        int n, len, k1, k2;
        logic [23:0] al = 24'h13579B, ar = 24'h2468AC, bl = 24'hF0E1D2, br = 24'h0F1E2D;
        n = 64; len = 3 * n + 4;
        do_reset(2'd0, 2'd1, 2'd0, 1'b1);
        repeat (3) @(posedge bck_o);
        #(CLK_PERIOD/2);
        check(underrun_o == 1'b1, "R11", "underrun with no pair at first start", underrun_o, 1);
        check(in_ready == 1'b1, "R10", "ready while empty", in_ready, 1);
        @(posedge bck_o);
        push(al, ar);
        check(in_ready == 1'b0, "R10", "ready after accept", in_ready, 0);
        push(bl, br);
        capture_master(len);
        k1 = find_start(1, len + 1, 2'd0);
        k2 = (k1 > 0) ? find_start(k1 + 1, len + 1, 2'd0) : -1;
        if (k1 > 0 && k2 > 0 && k2 + n <= len + 1) begin
            build_exp(2'd0, 2'd1, 2'd0, bl, br);
            compare_cap(k1, n, "R10", "waiting pair sent at next frame");
            check(cap_ur[k1+1] == 1'b0, "R11", "underrun clear when pair waits", cap_ur[k1+1], 0);
            compare_cap(k2, n, "R11", "pair repeated on underrun");
            check(cap_ur[k2+1] == 1'b1, "R11", "underrun set on repeat", cap_ur[k2+1], 1);
        end else begin
            check(1'b0, "R10", "frame starts not found", k1, 0);
        end
    endtask

    function automatic logic fck_val(input logic [1:0] f, input int b, input int len);
        if (f[1]) return (b == 0);
        if (f == 2'd0) return (b < len / 2);
        return (b >= len / 2);
    endfunction

    task automatic slave_run(input logic [1:0] f, input logic [1:0] s, input logic [1:0] sub,
                             input int nf, input logic [23:0] l, input logic [23:0] r);
        do_reset(f, s, sub, 1'b0);
        push(l, r);
        fck_i = (f == 2'd1);
        for (int b = 0; b < 3; b++) begin
            bck_i = 1'b0; #(SH*CLK_PERIOD);
            bck_i = 1'b1; #(SH*CLK_PERIOD);
        end
        check(sd_oe_o == 1'b0, "R8", "output off before first frame edge", sd_oe_o, 0);
        for (int fr = 0; fr < nf; fr++) begin
            for (int b = 0; b < sl_len[fr]; b++) begin
                bck_i = 1'b0;
                fck_i = fck_val(f, b, sl_len[fr]);
                #(SH*CLK_PERIOD);
                sl_sd[fr][b] = sd_o; sl_oe[fr][b] = sd_oe_o; sl_fe[fr][b] = frame_err_o;
                bck_i = 1'b1;
                #(SH*CLK_PERIOD);
            end
        end
    endtask

    task automatic compare_slave(input int fr, input int n, input string req, input string what);
        int mism;
        mism = 0;
        for (int i = 0; i < n; i++)
            if (sl_oe[fr][i] !== exp_oe[i] || (exp_oe[i] && sl_sd[fr][i] !== exp_d[i])) mism++;
        check(mism == 0, req, what, mism, 0);
    endtask

    task automatic test_slave_tdm_err();
        logic [23:0] l = 24'hC0FFEE, r = 24'h5A5A5A;
        sl_len[0] = 128; sl_len[1] = 128; sl_len[2] = 126; sl_len[3] = 128; sl_len[4] = 128;
        slave_run(2'd2, 2'd1, 2'd3, 5, l, r);
        build_exp(2'd2, 2'd1, 2'd3, l, r);
        compare_slave(0, 128, "R8", "slave first frame after rising edge");
        compare_slave(1, 128, "R5", "double speed sub-frame 3 placed as 1, enable only in slots (R6)");
        check(sl_fe[1][1] == 1'b0, "R9", "no error after good frame", sl_fe[1][1], 0);
        check(sl_fe[2][1] == 1'b0, "R9", "no error before short frame ends", sl_fe[2][1], 0);
        check(sl_fe[3][1] == 1'b1, "R9", "error after short frame", sl_fe[3][1], 1);
        check(sl_fe[4][1] == 1'b0, "R9", "error clears after good frame", sl_fe[4][1], 0);
    endtask

    task automatic test_slave_i2s();
        logic [23:0] l = 24'h800001, r = 24'h7FFFFE;
        sl_len[0] = 128; sl_len[1] = 128;
        slave_run(2'd1, 2'd0, 2'd0, 2, l, r);
        build_exp(2'd1, 2'd0, 2'd0, l, r);
        compare_slave(1, 128, "R8", "slave I2S frame from falling edge (R2)");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        test_reset_state();
        test_bck_period();
        test_master(2'd0, 2'd0, 2'd0, 24'hA5C3F1, 24'h3C5A96, "R1");
        test_master(2'd0, 2'd3, 2'd0, 24'h123456, 24'hFEDCBA, "R1");
        test_master(2'd1, 2'd2, 2'd0, 24'hB16B00, 24'h0DDF00, "R2");
        test_master(2'd2, 2'd0, 2'd2, 24'hABCDEF, 24'h987654, "R3");
        test_master(2'd3, 2'd0, 2'd3, 24'hFFFFFF, 24'hC3C3C3, "R3");
        test_master(2'd2, 2'd2, 2'd3, 24'h5EED11, 24'hA11CE5, "R5");
        test_master(2'd2, 2'd0, 2'd1, 24'h0F0F0F, 24'hF0F0F0, "R6");
        test_handshake_underrun();
        test_slave_tdm_err();
        test_slave_i2s();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule